// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This block watches 28 general-purpose input pins and records edges on them as sticky status bits. Each pin has its own enable for rising edges and its own enable for falling edges. Setting both enables makes the pin catch a change in either direction. Every input first passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one clock earlier.

Pins 0 to 10 each drive a dedicated interrupt line. Pins 11 to 27 share a single line, which is high while any of their status bits is set. A wake mask selects which pending status bits raise the wake request.

Software reaches four registers through a synchronous write port and a combinational read port. It clears status bits by writing ones to them. Writing back a value just read clears exactly the edges that were seen, and writing all ones clears everything. The block has no idle, busy or wait states: its behaviour is set entirely by the stored registers.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rising enables, falling enables, wake mask and status all read zero, and every interrupt and wake output is low.
- R2: A pin whose rising enable is set and whose falling enable is clear records a low-to-high change in its status bit. It ignores a high-to-low change.
- R3: A pin whose falling enable is set and whose rising enable is clear records a high-to-low change in its status bit. It ignores a low-to-high change.
- R4: A pin with both enables set records a change in either direction.
- R5: A status bit stays set until a write to the status register carries a 1 in that bit position. Bits written as 0 keep their value.
- R6: When a qualifying edge and a clearing write of the same bit land on the same clock, the bit ends up set.
- R7: The dedicated interrupt line `irq_direct[i]`, for i from 0 to 10, equals status bit i.
- R8: `irq_shared` is high exactly when any status bit from 11 to 27 is set.
- R9: `wake_req` is high exactly when some status bit is set whose wake mask bit is also set.
- R10: A pin change driven between clock edges shows in the status on the third rising clock edge after it, and not on the second.
- R11: Read data bits 31 to 28 are always zero, and writes to those bits are ignored in every register.
- R12: `reg_sel` selects the register:
  - 0: rising enables
  - 1: falling enables
  - 2: wake mask
  - 3: status

  A write lands on the clock edge where `reg_wen` is high. `reg_rdata` shows the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 28 | Raw, asynchronous pin levels |
| reg_sel | input | 2 | Register select (0 rise, 1 fall, 2 wake, 3 status) |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data; on status, ones clear bits |
| reg_rdata | output | 32 | Contents of the selected register |
| irq_direct | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt line for pins 11 to 27 |
| wake_req | output | 1 | Wake request from wake-masked pending edges |

## Verification
The assertions assume that `reg_sel`, `reg_wen` and `reg_wdata` hold steady around each rising clock edge. They also assume that a pin does not change twice within the three-cycle synchronizer window if a check depends on that pin's exact edge. The bench meets the first assumption by driving every input on the falling clock edge. In its random phase it toggles only a sparse, random subset of pins each cycle. A behavioural model fed the same samples keeps the expected status exact even when a pin glitches back and forth.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Register select codes seen on reg_sel
    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_WAKE = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_edge_sync.sv
// Multi-stage synchronizer plus one-cycle history for edge detection.
module gpio_edge_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] rise_det,
    output logic [WIDTH-1:0] fall_det
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] last_q;
    logic [WIDTH-1:0] synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
            last_q <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            last_q <= stage_q[STAGES-1];
        end
    end

    assign synced   = stage_q[STAGES-1];
    assign rise_det = synced & ~last_q;
    assign fall_det = ~synced & last_q;

endmodule

// File: rtl/gpio_edge_cfg.sv
// Configuration registers: rising enables, falling enables, wake mask.
module gpio_edge_cfg
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rise_en,
    output logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] wake_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            wake_en <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_RISE: rise_en <= wdata;
                SEL_FALL: fall_en <= wdata;
                SEL_WAKE: wake_en <= wdata;
                SEL_STAT: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_status.sv
// Sticky edge status, cleared by writing ones; a new edge beats a clear.
module gpio_edge_status #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_mask;
        end
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS    = 28,
    parameter int NUM_DIRECT  = 11,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_in,
    input  logic [1:0]            reg_sel,
    input  logic                  reg_wen,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_shared,
    output logic                  wake_req
);

    localparam int PAD_W = DATA_W - NUM_PINS;

    reg_sel_e            sel_e;
    logic [NUM_PINS-1:0] wdata_pins;
    logic [NUM_PINS-1:0] rise_det, fall_det;
    logic [NUM_PINS-1:0] rise_en, fall_en, wake_en;
    logic [NUM_PINS-1:0] qual_edges;
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] rd_sel_val;
    logic                unused_wdata_hi;

    assign sel_e           = reg_sel_e'(reg_sel);
    assign wdata_pins      = reg_wdata[NUM_PINS-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_PINS];

    gpio_edge_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pins_in),
        .rise_det (rise_det),
        .fall_det (fall_det)
    );

    gpio_edge_cfg #(
        .WIDTH (NUM_PINS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wen),
        .sel     (sel_e),
        .wdata   (wdata_pins),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .wake_en (wake_en)
    );

    assign qual_edges = (rise_det & rise_en) | (fall_det & fall_en);
    assign clr_mask   = (reg_wen && sel_e == SEL_STAT) ? wdata_pins : '0;

    gpio_edge_status #(
        .WIDTH (NUM_PINS)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (qual_edges),
        .clr_mask (clr_mask),
        .status   (status_q)
    );

    // Read mux: unused upper bits are padded with zeros
    always_comb begin
        unique case (sel_e)
            SEL_RISE: rd_sel_val = rise_en;
            SEL_FALL: rd_sel_val = fall_en;
            SEL_WAKE: rd_sel_val = wake_en;
            SEL_STAT: rd_sel_val = status_q;
        endcase
    end

    assign reg_rdata  = {{PAD_W{1'b0}}, rd_sel_val};
    assign irq_direct = status_q[NUM_DIRECT-1:0];
    assign irq_shared = |status_q[NUM_PINS-1:NUM_DIRECT];
    assign wake_req   = |(status_q & wake_en);

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int NUM_PINS   = 28,
    parameter int NUM_DIRECT = 11,
    parameter int DATA_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            reg_sel,
    input logic                  reg_wen,
    input logic [NUM_PINS-1:0]   reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic [NUM_DIRECT-1:0] irq_direct,
    input logic                  irq_shared,
    input logic                  wake_req,
    input logic [NUM_PINS-1:0]   status_q,
    input logic [NUM_PINS-1:0]   qual_edges
);

    logic [NUM_PINS-1:0] chk_clr;
    assign chk_clr = (reg_wen && reg_sel == 2'd3) ? reg_wdata : '0;

    // R2 R3 R4
    new_bit_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_q & ~$past(status_q) & ~$past(qual_edges)) == '0);

    // R5
    sticky_unless_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(status_q) & ~status_q & ~$past(chk_clr)) == '0);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(qual_edges) & ~status_q) == '0);

    // R7
    direct_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> irq_direct == reg_rdata[NUM_DIRECT-1:0]);

    // R8
    shared_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> irq_shared == (|reg_rdata[NUM_PINS-1:NUM_DIRECT]));

    // R9
    wake_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (irq_direct != '0 || irq_shared));

    // R11
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_PINS] == '0);

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .NUM_PINS   (NUM_PINS),
    .NUM_DIRECT (NUM_DIRECT),
    .DATA_W     (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wen    (reg_wen),
    .reg_wdata  (reg_wdata[NUM_PINS-1:0]),
    .reg_rdata  (reg_rdata),
    .irq_direct (irq_direct),
    .irq_shared (irq_shared),
    .wake_req   (wake_req),
    .status_q   (status_q),
    .qual_edges (qual_edges)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pins_in = '0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] irq_direct;
    logic        irq_shared;
    logic        wake_req;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_edge_irq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_in    (pins_in),
        .reg_sel    (reg_sel),
        .reg_wen    (reg_wen),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared),
        .wake_req   (wake_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: sample history queue, integer-free vectors
    logic [27:0] m_rise, m_fall, m_wake, m_stat;
    logic [27:0] hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rise = '0; m_fall = '0; m_wake = '0; m_stat = '0;
            hist = '{28'd0, 28'd0, 28'd0};
        end else begin
            logic [27:0] up, down, hit, wipe;
            up   = hist[1] & ~hist[0];
            down = ~hist[1] & hist[0];
            hit  = (up & m_rise) | (down & m_fall);
            wipe = (reg_wen && reg_sel == 2'd3) ? reg_wdata[27:0] : '0;
            m_stat = (m_stat & ~wipe) | hit;
            if (reg_wen) begin
                if (reg_sel == 2'd0) m_rise = reg_wdata[27:0];
                if (reg_sel == 2'd1) m_fall = reg_wdata[27:0];
                if (reg_sel == 2'd2) m_wake = reg_wdata[27:0];
            end
            hist.push_back(pins_in);
            void'(hist.pop_front());
        end
    end

    // Per-cycle comparison, well away from both clock edges
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            logic [27:0] sel_val;
            case (reg_sel)
                2'd0: sel_val = m_rise;
                2'd1: sel_val = m_fall;
                2'd2: sel_val = m_wake;
                default: sel_val = m_stat;
            endcase
            chk(reg_rdata == {4'h0, sel_val}, "R12 R11 model read", reg_rdata, {4'h0, sel_val});
            chk(irq_direct == m_stat[10:0], "R7 model direct", {21'd0, irq_direct}, {21'd0, m_stat[10:0]});
            chk(irq_shared == (|m_stat[27:11]), "R8 model shared", {31'd0, irq_shared}, {31'd0, |m_stat[27:11]});
            chk(wake_req == (|(m_stat & m_wake)), "R9 model wake", {31'd0, wake_req}, {31'd0, |(m_stat & m_wake)});
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wen = 1'b1; reg_wdata = data;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1 reset state, R12 map
        rd_chk(2'd0, 32'h0, "R1 rise after reset");
        rd_chk(2'd1, 32'h0, "R1 fall after reset");
        rd_chk(2'd2, 32'h0, "R1 wake after reset");
        rd_chk(2'd3, 32'h0, "R1 status after reset");
        chk(irq_direct == 0 && !irq_shared && !wake_req, "R1 outputs after reset",
            {19'd0, irq_direct, irq_shared, wake_req}, 32'h0);

        // R11 upper bits ignored
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h0FFF_FFFF, "R11 rise upper bits");
        wr(2'd0, 32'h0010_1003);
        wr(2'd1, 32'h0010_0020);
        wr(2'd2, 32'h0000_0002);
        rd_chk(2'd2, 32'h0000_0002, "R12 wake readback");

        // R10 latency on pin 1
        pins_in[1] = 1'b1;
        wait_cyc(2);
        rd_chk(2'd3, 32'h0, "R10 not yet after two edges");
        wait_cyc(1);
        rd_chk(2'd3, 32'h2, "R10 set on third edge");
        chk(wake_req, "R9 wake on masked pin", {31'd0, wake_req}, 32'h1);
        chk(irq_direct == 11'h002, "R7 direct pin1", {21'd0, irq_direct}, 32'h2);

        // R2 rising only on pin 0
        pins_in[0] = 1'b1;
        wait_cyc(4);
        rd_chk(2'd3, 32'h3, "R2 rise recorded");
        pins_in[0] = 1'b0;
        wait_cyc(4);
        rd_chk(2'd3, 32'h3, "R2 fall ignored");

        // R5 write-one-to-clear
        wr(2'd3, 32'h0);
        rd_chk(2'd3, 32'h3, "R5 zero write keeps");
        wr(2'd3, 32'h1);
        rd_chk(2'd3, 32'h2, "R5 single bit cleared");
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h0, "R5 all ones clears");
        chk(!wake_req, "R9 wake drops", {31'd0, wake_req}, 32'h0);

        // R3 falling only on pin 5
        pins_in[5] = 1'b1;
        wait_cyc(4);
        rd_chk(2'd3, 32'h0, "R3 rise ignored");
        pins_in[5] = 1'b0;
        wait_cyc(4);
        rd_chk(2'd3, 32'h20, "R3 fall recorded");
        chk(irq_direct == 11'h020, "R7 direct pin5", {21'd0, irq_direct}, 32'h20);
        wr(2'd3, 32'h20);

        // R4 both edges on pin 20, R8 shared line
        pins_in[20] = 1'b1;
        wait_cyc(4);
        rd_chk(2'd3, 32'h0010_0000, "R4 rise with both");
        chk(irq_shared && irq_direct == 0, "R8 shared high", {20'd0, irq_direct, irq_shared}, 32'h1);
        wr(2'd3, 32'h0010_0000);
        chk(!irq_shared, "R8 shared low after clear", {31'd0, irq_shared}, 32'h0);
        pins_in[20] = 1'b0;
        wait_cyc(4);
        rd_chk(2'd3, 32'h0010_0000, "R4 fall with both");
        wr(2'd3, 32'hFFFF_FFFF);

        // R6 edge and clear on the same clock, pin 12
        pins_in[12] = 1'b1;
        wait_cyc(4);
        rd_chk(2'd3, 32'h0000_1000, "R2 pin12 rise");
        wr(2'd1, 32'h0010_1020);
        pins_in[12] = 1'b0;
        wait_cyc(2);
        reg_sel = 2'd3; reg_wen = 1'b1; reg_wdata = 32'h0000_1000;
        @(negedge clk);
        reg_wen = 1'b0;
        rd_chk(2'd3, 32'h0000_1000, "R6 set wins over clear");
        wr(2'd3, 32'h0000_1000);
        rd_chk(2'd3, 32'h0, "R5 clear after collision");

        // R11 writes to upper status bits do nothing
        wr(2'd3, 32'hF000_0000);
        rd_chk(2'd3, 32'h0, "R11 status upper bits");

        // Random phase against the model
        wr(2'd0, 32'h0ACE_1357);
        wr(2'd1, 32'h0531_BEEF);
        wr(2'd2, 32'h0F00_F00F);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            pins_in = pins_in ^ 28'($urandom & $urandom & $urandom);
            reg_sel = 2'($urandom);
            reg_wen = ($urandom % 8) == 0;
            reg_wdata = $urandom;
        end
        @(negedge clk);
        reg_wen = 1'b0;
        wait_cyc(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule